// File: doc/BRIEF.md
# Panel Reset Pulse Pattern Generator

This block drives the reset line of an external display panel. On a start strobe it plays out a short bit pattern on the pin, one pattern bit per time slot. Bit 0 goes out first, and the slot length can be programmed. The slot length is counted in periods of a slow timebase. A two-stage power-of-two prescaler derives that timebase from the function clock. The second prescaler stage gives an even slower tick that neighbouring timeout logic can use.

Software sets the pattern, the number of bits to send, the slot width, the pin polarity and both prescaler ratios, then pulses `start_i`. While the pattern plays, `busy_o` is high. When the last slot ends, a single-cycle `done_o` pulse is raised so that interrupt logic outside the block can capture it. The pin then returns to its inactive level.

Top module: `panel_rst_seq`

## Requirements
- R1: After reset `panel_rst_o` is 1, `busy_o` is 0 and `done_o` is 0. While idle, the pin drives the inactive level for the live polarity: 1 when `act_high_i`=0 and 0 when `act_high_i`=1. A polarity change shows one cycle later.
- R2: A `start_i` sampled high while idle sets `busy_o`. In the next cycle the pin carries pattern bit 0. A bit value of 0 means reset asserted and 1 means released.
- R3: Pattern bits go out LSB first. Each bit is held for exactly W·2^ratio0 clock cycles, where W is the effective width. The first-stage prescaler restarts on an accepted start.
- R4: The number of bits sent is `pulse_cnt_i`, clamped to 1..8: 0 sends one bit and values above 8 send eight bits.
- R5: The effective width is `pulse_width_i`, clamped to 1..64: 0 acts as 1 and values above 64 act as 64.
- R6: With `act_high_i`=1 the pin level is the inverse of the pattern bit, so bit 0 drives 1.
- R7: On the clock edge that ends the last slot, `busy_o` falls, `done_o` rises for exactly one cycle and the pin returns to the inactive level.
- R8: A `start_i` that arrives while busy is ignored. The running sequence and both timebases keep their timing.
- R9: Pattern, bit count, width and polarity are captured at start. Changing them during a sequence has no effect on it.
- R10: `tb1_tick_o` is a one-cycle pulse with period 2^(ratio0+ratio1). After an accepted start it first pulses 2^(ratio0+ratio1) cycles after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Function clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request strobe |
| pattern_i | input | PAT_W | Bit pattern, bit 0 sent first |
| pulse_cnt_i | input | CNT_W | Number of bits to send (clamped 1..PAT_W) |
| pulse_width_i | input | WIDTH_W | Slot width in first-timebase periods (clamped 1..MAX_WIDTH) |
| act_high_i | input | 1 | 1 = pin asserts high, 0 = pin asserts low |
| ratio0_i | input | RATIO_W | First-stage divide exponent |
| ratio1_i | input | RATIO_W | Second-stage divide exponent |
| panel_rst_o | output | 1 | Panel reset pin |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| tb1_tick_o | output | 1 | Second timebase tick |

## Verification
All outputs are registered, so the start edge E0 is the reference point for every check. The first pattern bit and `busy_o` appear in the cycle after E0. Each bit changes on edge E0 + k·W·2^ratio0. `done_o` and the idle pin level appear after edge E0 + N·W·2^ratio0. The second-timebase tick appears after each edge E0 + m·2^(ratio0+ratio1).

The driver task computes this whole per-cycle trace from the inputs it applied and queues it at E0. A monitor then pops one entry at every falling edge and compares all four outputs. Because of this, an output that comes one cycle early or one cycle late is reported as a failure.

// File: rtl/prs_pkg.sv
package prs_pkg;

  // Pin level for a pattern bit: bit value 0 means "reset asserted".
  function automatic logic pin_level(input logic pat_bit, input logic act_high);
    return pat_bit ^ act_high;
  endfunction

  // Inactive (released) pin level for a polarity.
  function automatic logic idle_level(input logic act_high);
    return ~act_high;
  endfunction

endpackage

// File: rtl/prs_prescaler.sv
module prs_prescaler #(
  parameter int RATIO_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic [RATIO_W-1:0] ratio0,
  input  logic [RATIO_W-1:0] ratio1,
  output logic               tick0_o,
  output logic               tick1_o
);
  localparam int CW = 1 << RATIO_W;

  logic [CW-1:0] c0_q, c1_q, mask0, mask1;
  logic          tick1_q;

  assign mask0   = (CW'(1) << ratio0) - CW'(1);
  assign mask1   = (CW'(1) << ratio1) - CW'(1);
  assign tick0_o = (c0_q == mask0);
  assign tick1_o = tick1_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      c0_q    <= '0;
      c1_q    <= '0;
      tick1_q <= 1'b0;
    end else begin
      tick1_q <= 1'b0;
      if (tick0_o) begin
        c0_q <= '0;
        if (c1_q == mask1) begin
          c1_q    <= '0;
          tick1_q <= 1'b1;
        end else begin
          c1_q <= c1_q + CW'(1);
        end
      end else begin
        c0_q <= c0_q + CW'(1);
      end
    end
  end

  AST_TB1_ON_TB0: assert property (@(posedge clk) disable iff (rst)
    tick1_q |-> $past(tick0_o)) else $error("tb1 without tb0"); // R10
  AST_TB1_CLEARED: assert property (@(posedge clk) disable iff (rst)
    $past(clear) |-> !tick1_q) else $error("tb1 after clear"); // R10
endmodule

// File: rtl/prs_sequencer.sv
module prs_sequencer
  import prs_pkg::*;
#(
  parameter int PAT_W     = 8,
  parameter int MAX_WIDTH = 64,
  parameter int CNT_W     = $clog2(PAT_W) + 1,
  parameter int WIDTH_W   = $clog2(MAX_WIDTH) + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick0,
  input  logic               start,
  input  logic [PAT_W-1:0]   pattern,
  input  logic [CNT_W-1:0]   pulse_cnt,
  input  logic [WIDTH_W-1:0] pulse_width,
  input  logic               act_high,
  output logic               accept_o,
  output logic               pin_o,
  output logic               busy_o,
  output logic               done_o
);
  localparam int IDX_W  = (PAT_W > 1) ? $clog2(PAT_W) : 1;
  localparam int WCNT_W = (MAX_WIDTH > 1) ? $clog2(MAX_WIDTH) : 1;

  logic [PAT_W-1:0]  pat_q;
  logic [IDX_W-1:0]  idx_q, last_idx_q, last_idx_d;
  logic [WCNT_W-1:0] wcnt_q, last_w_q, last_w_d;
  logic              pol_q, busy_q, done_q, pin_q;

  assign accept_o = start && !busy_q;
  assign pin_o    = pin_q;
  assign busy_o   = busy_q;
  assign done_o   = done_q;

  // Clamp bit count to 1..PAT_W, stored as last index.
  always_comb begin
    if (pulse_cnt == '0)
      last_idx_d = '0;
    else if (pulse_cnt > CNT_W'(PAT_W))
      last_idx_d = IDX_W'(PAT_W - 1);
    else
      last_idx_d = IDX_W'(pulse_cnt - CNT_W'(1));
  end

  // Clamp width to 1..MAX_WIDTH, stored as last count.
  always_comb begin
    if (pulse_width == '0)
      last_w_d = '0;
    else if (pulse_width > WIDTH_W'(MAX_WIDTH))
      last_w_d = WCNT_W'(MAX_WIDTH - 1);
    else
      last_w_d = WCNT_W'(pulse_width - WIDTH_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      pin_q      <= 1'b1;
      pat_q      <= '0;
      pol_q      <= 1'b0;
      idx_q      <= '0;
      wcnt_q     <= '0;
      last_idx_q <= '0;
      last_w_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept_o) begin
        busy_q     <= 1'b1;
        pat_q      <= pattern;
        pol_q      <= act_high;
        last_idx_q <= last_idx_d;
        last_w_q   <= last_w_d;
        idx_q      <= '0;
        wcnt_q     <= '0;
        pin_q      <= pin_level(pattern[0], act_high);
      end else if (busy_q) begin
        if (tick0) begin
          if (wcnt_q == last_w_q) begin
            wcnt_q <= '0;
            if (idx_q == last_idx_q) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
              pin_q  <= idle_level(pol_q);
            end else begin
              idx_q <= idx_q + IDX_W'(1);
              pin_q <= pin_level(pat_q[idx_q + IDX_W'(1)], pol_q);
            end
          end else begin
            wcnt_q <= wcnt_q + WCNT_W'(1);
          end
        end
      end else begin
        pin_q <= idle_level(act_high);
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q) else $error("done longer than one cycle"); // R7
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (!busy_q && $past(busy_q))) else $error("done without busy end"); // R7
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (idx_q <= last_idx_q)) else $error("bit index past count"); // R4
  AST_PIN_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q) && !$past(tick0)) |-> $stable(pin_q)) else $error("pin moved off tick"); // R3
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> ($stable(pat_q) && $stable(pol_q) && $stable(last_w_q))) else $error("config changed while busy"); // R9
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !done_q && !$past(busy_q) && !$past(rst)) |-> (pin_q == ~$past(act_high))) else $error("idle pin level"); // R1
endmodule

// File: rtl/panel_rst_seq.sv
module panel_rst_seq #(
  parameter int PAT_W     = 8,
  parameter int MAX_WIDTH = 64,
  parameter int RATIO_W   = 4,
  parameter int CNT_W     = $clog2(PAT_W) + 1,
  parameter int WIDTH_W   = $clog2(MAX_WIDTH) + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [PAT_W-1:0]   pattern_i,
  input  logic [CNT_W-1:0]   pulse_cnt_i,
  input  logic [WIDTH_W-1:0] pulse_width_i,
  input  logic               act_high_i,
  input  logic [RATIO_W-1:0] ratio0_i,
  input  logic [RATIO_W-1:0] ratio1_i,
  output logic               panel_rst_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               tb1_tick_o
);
  logic tick0, accept;

  prs_prescaler #(.RATIO_W(RATIO_W)) u_pre (
    .clk(clk), .rst(rst), .clear(accept),
    .ratio0(ratio0_i), .ratio1(ratio1_i),
    .tick0_o(tick0), .tick1_o(tb1_tick_o)
  );

  prs_sequencer #(
    .PAT_W(PAT_W), .MAX_WIDTH(MAX_WIDTH), .CNT_W(CNT_W), .WIDTH_W(WIDTH_W)
  ) u_seq (
    .clk(clk), .rst(rst), .tick0(tick0), .start(start_i),
    .pattern(pattern_i), .pulse_cnt(pulse_cnt_i), .pulse_width(pulse_width_i),
    .act_high(act_high_i), .accept_o(accept),
    .pin_o(panel_rst_o), .busy_o(busy_o), .done_o(done_o)
  );

  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
    ($past(busy_o) && $past(start_i) && !$past(done_o) && busy_o) |-> !done_o) else $error("restart while busy"); // R8
endmodule

// File: tb/panel_rst_seq_tb.sv
module panel_rst_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [7:0] pattern_i = '0;
  logic [3:0] pulse_cnt_i = 4'd1;
  logic [6:0] pulse_width_i = 7'd1;
  logic       act_high_i = 1'b0;
  logic [3:0] ratio0_i = '0;
  logic [3:0] ratio1_i = '0;
  logic       panel_rst_o, busy_o, done_o, tb1_tick_o;

  always #4 clk = ~clk;

  panel_rst_seq dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .pattern_i(pattern_i),
    .pulse_cnt_i(pulse_cnt_i), .pulse_width_i(pulse_width_i),
    .act_high_i(act_high_i), .ratio0_i(ratio0_i), .ratio1_i(ratio1_i),
    .panel_rst_o(panel_rst_o), .busy_o(busy_o), .done_o(done_o),
    .tb1_tick_o(tb1_tick_o)
  );

  typedef struct {
    logic  pin;
    logic  busy;
    logic  done;
    logic  tb1;
    string req;
  } exp_t;

  exp_t  q[$];
  int    checks = 0;
  int    failures = 0;
  string scen = "reset";
  bit    finished = 0;

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Monitor: one expected entry per cycle, compared away from the rising edge.
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if ({panel_rst_o, busy_o, done_o} !== {e.pin, e.busy, e.done}) begin
          failures++;
          $display("FAIL %s [%s] pin/busy/done actual=%b%b%b expected=%b%b%b",
                   e.req, scen, panel_rst_o, busy_o, done_o, e.pin, e.busy, e.done);
        end else if (tb1_tick_o !== e.tb1) begin
          failures++;
          $display("FAIL R10 [%s] tb1 actual=%b expected=%b", scen, tb1_tick_o, e.tb1);
        end
      end
    end
  end

  task automatic direct_check(input string req, input logic [2:0] act, input logic [2:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s pin/busy/done actual=%b expected=%b", req, act, expv);
    end
  endtask

  // Driver: launches a sequence and queues its whole expected trace.
  task automatic run_seq(input string name, input logic [7:0] pat, input int n,
                         input int w, input logic ph, input int r0, input int r1,
                         input bit disturb);
    int neff, weff, p, qp, len;
    logic ph_end;
    exp_t e;
    scen = name;
    neff = (n == 0) ? 1 : ((n > 8) ? 8 : n);
    weff = (w == 0) ? 1 : ((w > 64) ? 64 : w);
    p = 1 << r0;
    qp = 1 << (r0 + r1);
    len = neff * weff * p;
    ph_end = disturb ? ~ph : ph;
    @(negedge clk);
    pattern_i = pat; pulse_cnt_i = 4'(n); pulse_width_i = 7'(w);
    act_high_i = ph; ratio0_i = 4'(r0); ratio1_i = 4'(r1);
    start_i = 1'b1;
    @(posedge clk);
    for (int k = 0; k < len; k++) begin
      e.pin = pat[k / (weff * p)] ^ ph;
      e.busy = 1'b1; e.done = 1'b0;
      e.tb1 = (k > 0) && (k % qp == 0);
      e.req = (k == 0) ? "R2" : "R3";
      q.push_back(e);
    end
    e.pin = ~ph; e.busy = 1'b0; e.done = 1'b1;
    e.tb1 = (len % qp == 0); e.req = "R7";
    q.push_back(e);
    e.pin = ~ph_end; e.busy = 1'b0; e.done = 1'b0;
    e.tb1 = ((len + 1) % qp == 0); e.req = "R1";
    q.push_back(e);
    @(negedge clk);
    start_i = 1'b0;
    if (disturb) begin
      repeat (5) @(negedge clk);
      pattern_i = ~pat; pulse_cnt_i = 4'd1; pulse_width_i = 7'd1;
      act_high_i = ~ph; start_i = 1'b1;   // R8 R9: all of this must be ignored
      @(negedge clk);
      start_i = 1'b0;
    end
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    direct_check("R1", {panel_rst_o, busy_o, done_o}, 3'b100);
    act_high_i = 1'b1;
    @(negedge clk);
    direct_check("R1", {panel_rst_o, busy_o, done_o}, 3'b000);
    act_high_i = 1'b0;
    @(negedge clk);
    direct_check("R1", {panel_rst_o, busy_o, done_o}, 3'b100);

    run_seq("R3 lsb-first", 8'b1010_0110, 8, 3, 1'b0, 1, 2, 1'b0);
    run_seq("R4 count0", 8'h00, 0, 2, 1'b0, 0, 0, 1'b0);
    run_seq("R4 count12", 8'h5A, 12, 1, 1'b0, 0, 1, 1'b0);
    run_seq("R5 width0", 8'b0000_0101, 3, 0, 1'b0, 2, 1, 1'b0);
    run_seq("R5 width100", 8'b0000_0010, 2, 100, 1'b0, 0, 3, 1'b0);
    run_seq("R6 active-high", 8'b0000_0110, 4, 2, 1'b1, 1, 1, 1'b0);
    run_seq("R8 R9 disturb", 8'hC3, 6, 2, 1'b0, 1, 2, 1'b1);
    run_seq("R10 slow", 8'hFE, 2, 4, 1'b0, 2, 2, 1'b0);
    report();
  end
endmodule